// File: doc/BRIEF.md
# Port Group Forwarding Mask Resolver

This block works out the egress port set of a layer-2 frame inside a small Ethernet switch. It holds a table of port-group masks, one bit per physical port plus one bit for the CPU port. The CPU bit sits at index N, directly above the last physical port. A lookup request reads three entries from the table in parallel: a destination group, an aggregation group and a source group. The bitwise AND of the three is the set of ports the frame may leave on.

The destination group comes from the MAC table when the destination address and VLAN pair was found there. Otherwise it is one of five fixed flood entries, picked by the frame's class. The aggregation group is indexed by the frame's 4-bit link aggregation code, so that each flow leaves on only one member of a bundle. The source group is indexed by the ingress port, so that it acts as a permission matrix between ingress and egress ports.

Software fills the table through a simple write port and can read it back through a separate read port. Table layout: entries 0 to N-1 are per-port unicast masks, entries N to 63 are multicast sets, 57 is the drop entry, 58 is the CPU entry, 59 to 63 are flood entries, 64 to 79 are aggregation entries, and 80 to 80+N-1 are source entries.

Top module: `pgmask_resolver`

A two-state output sequencer drives the result. State RS_IDLE means no result is present. State RS_EMIT means a result is present on this cycle. The transitions are:
- RS_IDLE goes to RS_EMIT on a request.
- RS_EMIT stays in RS_EMIT on a further request.
- RS_EMIT goes back to RS_IDLE when no request is present.

## Requirements
- R1: A request sampled with `lk_valid` high yields `res_valid` high in exactly the next cycle. `res_mask` is then the AND of the destination, aggregation and source entries. A new request is accepted every cycle, and without a request `res_valid` is low.
- R2: With `lk_hit` high and `lk_dest` below 64, the destination entry index is `lk_dest`.
- R3: With `lk_hit` low, the destination entry is chosen from `lk_class` as follows:
  - 0 (unicast) selects 59.
  - 1 (non-IP multicast) selects 60.
  - 2 (IPv4 multicast) selects 61.
  - 3 (IPv6 multicast) selects 62.
  - 4 (broadcast) selects 63.
  - Codes 5 to 7 select the drop entry 57.
- R4: The aggregation entry index is 64 plus `lk_aggr`.
- R5: The source entry index is 80 plus `lk_port`, and bit j of that entry permits forwarding to port j. An `lk_port` of N or above yields an all-zero mask.
- R6: With `lk_hit` high and `lk_dest` of 64 or above, the result mask is all zero.
- R7: `res_drop` is high exactly when `res_valid` is high and `res_mask` is zero.
- R8: Reset clears every table entry to zero and drives `res_valid` and `res_drop` low. After reset, any lookup is a drop.
- R9: A write with `cfg_we` high lands at the next clock edge. A lookup issued in the same cycle as the write still sees the old value, and a lookup issued in the following cycle sees the new one. `cfg_rdata` shows the entry at `cfg_raddr` combinationally.
- R10: Writes to an address of 80+N or above are ignored, and reads from such an address return zero.
- R11: The CPU port is bit N of every mask, and it passes through the AND like any other port bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write enable |
| cfg_waddr | input | 7 | Table write address |
| cfg_wdata | input | NUM_PORTS+1 | Table write data |
| cfg_raddr | input | 7 | Table read address |
| cfg_rdata | output | NUM_PORTS+1 | Table read data, combinational |
| lk_valid | input | 1 | Lookup request strobe |
| lk_port | input | clog2(NUM_PORTS) | Ingress port number |
| lk_hit | input | 1 | The MAC table found the destination |
| lk_dest | input | 7 | Destination index from the MAC table |
| lk_class | input | 3 | Frame class code (see R3) |
| lk_aggr | input | 4 | Link aggregation code |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| res_mask | output | NUM_PORTS+1 | Egress port mask, CPU at bit NUM_PORTS |
| res_drop | output | 1 | Result mask is empty |

## Verification
The bound checker watches every cycle for the following:
- The one-cycle request-to-result timing and the absence of spurious results.
- The forced drop for an out-of-range destination index or ingress port.
- The agreement between `res_drop` and an empty mask.
- The write-then-read visibility of the table, and the zero read-back above the table.

Which entries are combined, the class-to-flood mapping, the aggregation and source indexing, and the rule that a same-cycle write is not yet visible cannot be expressed by those properties. Only the bench's scenarios can show them, by comparing each result against a shadow copy of what was written.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
    localparam int IDX_W      = 7;
    localparam int DEST_SPAN  = 64;
    localparam int AGGR_BASE  = 64;
    localparam int AGGR_W     = 4;
    localparam int SRC_BASE   = 80;
    localparam int CLASS_W    = 3;

    localparam logic [IDX_W-1:0] IDX_DROP   = 7'd57;
    localparam logic [IDX_W-1:0] IDX_CPU    = 7'd58;
    localparam logic [IDX_W-1:0] IDX_FL_UC  = 7'd59;
    localparam logic [IDX_W-1:0] IDX_FL_MC  = 7'd60;
    localparam logic [IDX_W-1:0] IDX_FL_V4  = 7'd61;
    localparam logic [IDX_W-1:0] IDX_FL_V6  = 7'd62;
    localparam logic [IDX_W-1:0] IDX_FL_BC  = 7'd63;

    typedef enum logic [CLASS_W-1:0] {
        FC_UCAST  = 3'd0,
        FC_MCAST  = 3'd1,
        FC_IPV4MC = 3'd2,
        FC_IPV6MC = 3'd3,
        FC_BCAST  = 3'd4
    } frame_class_t;

    typedef enum logic {
        RS_IDLE = 1'b0,
        RS_EMIT = 1'b1
    } res_state_t;
endpackage

// File: rtl/pgm_index.sv
module pgm_index
    import pgm_pkg::*;
#(
    parameter int NUM_PORTS = 11,
    parameter int PORT_W    = 4
) (
    input  logic               lk_hit,
    input  logic [IDX_W-1:0]   lk_dest,
    input  logic [CLASS_W-1:0] lk_class,
    input  logic [AGGR_W-1:0]  lk_aggr,
    input  logic [PORT_W-1:0]  lk_port,
    output logic [IDX_W-1:0]   dest_idx,
    output logic [IDX_W-1:0]   aggr_idx,
    output logic [IDX_W-1:0]   src_idx,
    output logic               kill
);
    logic [IDX_W-1:0] flood_idx;
    logic             bad_dest;
    logic             bad_port;

    // Unknown destination: flood entry by frame class, drop entry otherwise.
    always_comb begin
        case (frame_class_t'(lk_class))
            FC_UCAST:  flood_idx = IDX_FL_UC;
            FC_MCAST:  flood_idx = IDX_FL_MC;
            FC_IPV4MC: flood_idx = IDX_FL_V4;
            FC_IPV6MC: flood_idx = IDX_FL_V6;
            FC_BCAST:  flood_idx = IDX_FL_BC;
            default:   flood_idx = IDX_DROP;
        endcase
    end

    assign bad_dest = lk_hit && (lk_dest >= IDX_W'(DEST_SPAN));
    assign bad_port = (int'(lk_port) >= NUM_PORTS);
    assign kill     = bad_dest || bad_port;

    assign dest_idx = lk_hit ? lk_dest : flood_idx;
    assign aggr_idx = IDX_W'(AGGR_BASE) + IDX_W'(lk_aggr);
    assign src_idx  = IDX_W'(SRC_BASE) + IDX_W'(lk_port);
endmodule

// File: rtl/pgm_table.sv
module pgm_table
    import pgm_pkg::*;
#(
    parameter int NUM_ENTRIES = 91,
    parameter int MASK_W      = 12,
    parameter int NUM_RD      = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_addr,
    input  logic [MASK_W-1:0]              wr_data,
    input  logic [NUM_RD-1:0][IDX_W-1:0]   rd_addr,
    output logic [NUM_RD-1:0][MASK_W-1:0]  rd_data
);
    logic [MASK_W-1:0] mem [NUM_ENTRIES];

    // One register per entry; an address beyond the table matches none.
    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[e] <= '0;
            end else if (wr_en && (wr_addr == IDX_W'(e))) begin
                mem[e] <= wr_data;
            end
        end
    end

    // Parallel combinational read ports; beyond the table reads as zero.
    for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
        always_comb begin
            if (rd_addr[r] < IDX_W'(NUM_ENTRIES)) begin
                rd_data[r] = mem[rd_addr[r]];
            end else begin
                rd_data[r] = '0;
            end
        end
    end
endmodule

// File: rtl/pgm_result.sv
module pgm_result
    import pgm_pkg::*;
#(
    parameter int MASK_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              kill,
    input  logic [MASK_W-1:0] dest_mask,
    input  logic [MASK_W-1:0] aggr_mask,
    input  logic [MASK_W-1:0] src_mask,
    output logic              res_valid,
    output logic [MASK_W-1:0] res_mask,
    output logic              res_drop
);
    res_state_t        state_q;
    res_state_t        state_d;
    logic [MASK_W-1:0] combined;

    assign combined = kill ? '0 : (dest_mask & aggr_mask & src_mask);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE: if (req)  state_d = RS_EMIT;
            RS_EMIT: if (!req) state_d = RS_IDLE;
            default:           state_d = RS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_IDLE;
        else        state_q <= state_d;
    end

    // Output registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_mask <= '0;
            res_drop <= 1'b0;
        end else if (req) begin
            res_mask <= combined;
            res_drop <= (combined == '0);
        end else begin
            res_mask <= '0;
            res_drop <= 1'b0;
        end
    end

    assign res_valid = (state_q == RS_EMIT);
endmodule

// File: rtl/pgmask_resolver.sv
module pgmask_resolver
    import pgm_pkg::*;
#(
    parameter int NUM_PORTS = 11,
    localparam int MASK_W   = NUM_PORTS + 1,
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [6:0]         cfg_waddr,
    input  logic [MASK_W-1:0]  cfg_wdata,
    input  logic [6:0]         cfg_raddr,
    output logic [MASK_W-1:0]  cfg_rdata,
    input  logic               lk_valid,
    input  logic [PORT_W-1:0]  lk_port,
    input  logic               lk_hit,
    input  logic [6:0]         lk_dest,
    input  logic [2:0]         lk_class,
    input  logic [3:0]         lk_aggr,
    output logic               res_valid,
    output logic [MASK_W-1:0]  res_mask,
    output logic               res_drop
);
    localparam int NUM_ENTRIES = SRC_BASE + NUM_PORTS;
    localparam int RD_DEST = 0;
    localparam int RD_AGGR = 1;
    localparam int RD_SRC  = 2;
    localparam int RD_CFG  = 3;
    localparam int NUM_RD  = 4;

    logic [IDX_W-1:0]              dest_idx;
    logic [IDX_W-1:0]              aggr_idx;
    logic [IDX_W-1:0]              src_idx;
    logic                          kill;
    logic [NUM_RD-1:0][IDX_W-1:0]  rd_addr;
    logic [NUM_RD-1:0][MASK_W-1:0] rd_data;

    pgm_index #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_index (
        .lk_hit   (lk_hit),
        .lk_dest  (lk_dest),
        .lk_class (lk_class),
        .lk_aggr  (lk_aggr),
        .lk_port  (lk_port),
        .dest_idx (dest_idx),
        .aggr_idx (aggr_idx),
        .src_idx  (src_idx),
        .kill     (kill)
    );

    always_comb begin
        rd_addr          = '0;
        rd_addr[RD_DEST] = dest_idx;
        rd_addr[RD_AGGR] = aggr_idx;
        rd_addr[RD_SRC]  = src_idx;
        rd_addr[RD_CFG]  = cfg_raddr;
    end

    pgm_table #(.NUM_ENTRIES(NUM_ENTRIES), .MASK_W(MASK_W), .NUM_RD(NUM_RD)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_addr (cfg_waddr),
        .wr_data (cfg_wdata),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    assign cfg_rdata = rd_data[RD_CFG];

    pgm_result #(.MASK_W(MASK_W)) u_result (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (lk_valid),
        .kill      (kill),
        .dest_mask (rd_data[RD_DEST]),
        .aggr_mask (rd_data[RD_AGGR]),
        .src_mask  (rd_data[RD_SRC]),
        .res_valid (res_valid),
        .res_mask  (res_mask),
        .res_drop  (res_drop)
    );
endmodule

// File: rtl/pgmask_resolver_chk.sv
module pgmask_resolver_chk #(
    parameter int NUM_PORTS = 11,
    parameter int MASK_W    = 12,
    parameter int PORT_W    = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [6:0]        cfg_waddr,
    input logic [MASK_W-1:0] cfg_wdata,
    input logic [6:0]        cfg_raddr,
    input logic [MASK_W-1:0] cfg_rdata,
    input logic              lk_valid,
    input logic [PORT_W-1:0] lk_port,
    input logic              lk_hit,
    input logic [6:0]        lk_dest,
    input logic              res_valid,
    input logic [MASK_W-1:0] res_mask,
    input logic              res_drop
);
    localparam int TOP_ADDR = 80 + NUM_PORTS;

    assert_req_gives_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);

    assert_no_spurious_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid);

    assert_bad_port_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && (int'(lk_port) >= NUM_PORTS)) |=> (res_drop && (res_mask == '0)));

    assert_bad_dest_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_hit && (lk_dest >= 7'd64)) |=> (res_drop && (res_mask == '0)));

    assert_empty_is_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (res_mask == '0)) |-> res_drop);

    assert_drop_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_drop |-> (res_valid && (res_mask == '0)));

    assert_write_visible_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_we) && (int'($past(cfg_waddr)) < TOP_ADDR)
         && (cfg_raddr == $past(cfg_waddr))) |-> (cfg_rdata == $past(cfg_wdata)));

    assert_high_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cfg_raddr) >= TOP_ADDR) |-> (cfg_rdata == '0));
endmodule

bind pgmask_resolver pgmask_resolver_chk #(
    .NUM_PORTS (NUM_PORTS),
    .MASK_W    (MASK_W),
    .PORT_W    (PORT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_waddr (cfg_waddr),
    .cfg_wdata (cfg_wdata),
    .cfg_raddr (cfg_raddr),
    .cfg_rdata (cfg_rdata),
    .lk_valid  (lk_valid),
    .lk_port   (lk_port),
    .lk_hit    (lk_hit),
    .lk_dest   (lk_dest),
    .res_valid (res_valid),
    .res_mask  (res_mask),
    .res_drop  (res_drop)
);

// File: tb/sim_pgmask_resolver.sv
module sim_pgmask_resolver;
    localparam int CLK_PERIOD = 10;
    localparam int NP   = 11;
    localparam int MW   = NP + 1;
    localparam int TOP  = 80 + NP;
    localparam int NV   = 14;

    // Vector: {port[3:0], hit, dest[6:0], class[2:0], aggr[3:0]}
    localparam logic [18:0] VEC [NV] = '{
        {4'd0,  1'b1, 7'd4,  3'd0, 4'd0},   // R2 unicast entry
        {4'd1,  1'b1, 7'd20, 3'd0, 4'd1},   // R2 R4 odd code
        {4'd1,  1'b1, 7'd20, 3'd0, 4'd0},   // R4 even code
        {4'd2,  1'b0, 7'd0,  3'd0, 4'd2},   // R3 unicast flood
        {4'd2,  1'b0, 7'd0,  3'd1, 4'd2},   // R3 mcast flood
        {4'd3,  1'b0, 7'd0,  3'd2, 4'd3},   // R3 ipv4
        {4'd4,  1'b0, 7'd0,  3'd3, 4'd4},   // R3 ipv6
        {4'd0,  1'b0, 7'd0,  3'd4, 4'd5},   // R3 broadcast
        {4'd2,  1'b0, 7'd0,  3'd6, 4'd2},   // R3 undefined class
        {4'd6,  1'b1, 7'd58, 3'd0, 4'd6},   // R11 cpu
        {4'd5,  1'b0, 7'd0,  3'd4, 4'd7},   // R5 restricted source
        {4'd1,  1'b1, 7'd70, 3'd0, 4'd0},   // R6 bad dest
        {4'd12, 1'b0, 7'd0,  3'd4, 4'd0},   // R5 bad port
        {4'd0,  1'b1, 7'd0,  3'd0, 4'd0}    // R5 self blocked
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [6:0]    cfg_waddr = '0;
    logic [MW-1:0] cfg_wdata = '0;
    logic [6:0]    cfg_raddr = '0;
    logic [MW-1:0] cfg_rdata;
    logic          lk_valid = 1'b0;
    logic [3:0]    lk_port = '0;
    logic          lk_hit = 1'b0;
    logic [6:0]    lk_dest = '0;
    logic [2:0]    lk_class = '0;
    logic [3:0]    lk_aggr = '0;
    logic          res_valid;
    logic [MW-1:0] res_mask;
    logic          res_drop;

    logic [MW-1:0] shadow [128];
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgmask_resolver #(.NUM_PORTS(NP)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr),
        .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
        .lk_valid(lk_valid), .lk_port(lk_port), .lk_hit(lk_hit), .lk_dest(lk_dest),
        .lk_class(lk_class), .lk_aggr(lk_aggr), .res_valid(res_valid),
        .res_mask(res_mask), .res_drop(res_drop)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [MW-1:0] model(input logic [18:0] v);
        logic [3:0] p = v[18:15];
        logic       h = v[14];
        logic [6:0] d = v[13:7];
        logic [2:0] c = v[6:4];
        logic [3:0] a = v[3:0];
        int di;
        if (h) begin
            if (d >= 7'd64) return '0;
            di = int'(d);
        end else begin
            case (c)
                3'd0: di = 59;
                3'd1: di = 60;
                3'd2: di = 61;
                3'd3: di = 62;
                3'd4: di = 63;
                default: di = 57;
            endcase
        end
        return shadow[di] & shadow[64 + int'(a)] & shadow[80 + int'(p)];
    endfunction

    task automatic cfg_write(input int addr, input logic [MW-1:0] data);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_waddr = 7'(addr);
        cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
        if (addr < TOP) shadow[addr] = data;
    endtask

    task automatic drive(input logic [18:0] v);
        lk_valid = 1'b1;
        lk_port  = v[18:15];
        lk_hit   = v[14];
        lk_dest  = v[13:7];
        lk_class = v[6:4];
        lk_aggr  = v[3:0];
    endtask

    task automatic check_result(input string req, input logic [MW-1:0] exp);
        check({req, " valid"}, 32'(res_valid), 32'd1);
        check({req, " mask"}, 32'(res_mask), 32'(exp));
        check({req, " drop"}, 32'(res_drop), 32'(exp == '0));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 128; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 valid in reset", 32'(res_valid), 32'd0);
        check("R8 drop in reset", 32'(res_drop), 32'd0);
        rst_n = 1'b1;
        foreach (VEC[k]) begin
            if (k == 0 || k == 9 || k == 13) begin
                cfg_raddr = 7'(int'(VEC[k][13:7]) + 58 * int'(k == 9));
                #1 check("R8 table cleared", 32'(cfg_rdata), 32'd0);
            end
        end
        // R8: lookup on an empty table drops
        @(negedge clk);
        drive(VEC[3]);
        @(negedge clk);
        lk_valid = 1'b0;
        check_result("R8 empty lookup", '0);

        // Configure
        for (int p = 0; p < NP; p++) cfg_write(p, MW'(1) << p);
        cfg_write(20, 12'h0A5);
        cfg_write(57, 12'h000);
        cfg_write(58, 12'h800);
        cfg_write(59, 12'h0FF);
        cfg_write(60, 12'h3F0);
        cfg_write(61, 12'h00F);
        cfg_write(62, 12'h0F0);
        cfg_write(63, 12'hFFF);
        for (int c = 0; c < 16; c++) cfg_write(64 + c, (c % 2 == 1) ? 12'hFFB : 12'hFF7);
        for (int p = 0; p < NP; p++) cfg_write(80 + p, (p == 5) ? 12'h801 : (12'hFFF & ~(MW'(1) << p)));
        cfg_raddr = 7'd20;
        #1 check("R9 readback", 32'(cfg_rdata), 32'h0A5);
        cfg_raddr = 7'd85;
        #1 check("R9 readback src", 32'(cfg_rdata), 32'h801);

        // Vector walk, one request per cycle (R1 throughput)
        for (int i = 0; i <= NV; i++) begin
            @(negedge clk);
            if (i > 0) check_result($sformatf("R1 vector %0d", i - 1), model(VEC[i - 1]));
            if (i < NV) drive(VEC[i]);
            else lk_valid = 1'b0;
        end
        @(negedge clk);
        check("R1 idle no result", 32'(res_valid), 32'd0);

        // R9: same-cycle write not seen, next-cycle write seen
        cfg_we = 1'b1;
        cfg_waddr = 7'd4;
        cfg_wdata = 12'h030;
        drive(VEC[0]);
        @(negedge clk);
        cfg_we = 1'b0;
        check_result("R9 same cycle old", 12'h010);
        shadow[4] = 12'h030;
        @(negedge clk);
        lk_valid = 1'b0;
        check_result("R9 next cycle new", 12'h030);

        // R10: write above the table ignored, read returns zero
        cfg_write(100, 12'hFFF);
        cfg_raddr = 7'd100;
        #1 check("R10 high read", 32'(cfg_rdata), 32'd0);
        cfg_raddr = 7'd4;
        #1 check("R10 table intact", 32'(cfg_rdata), 32'h030);

        // R8: reset mid-run clears the table
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 valid after reset", 32'(res_valid), 32'd0);
        cfg_raddr = 7'd63;
        #1 check("R8 entry cleared", 32'(cfg_rdata), 32'd0);
        rst_n = 1'b1;
        for (int i = 0; i < 128; i++) shadow[i] = '0;
        @(negedge clk);
        drive(VEC[7]);
        @(negedge clk);
        lk_valid = 1'b0;
        check_result("R8 drop after reset", '0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule